// File: doc/BRIEF.md
# Isochronous Cycle Timer with Extended Bus Time

The block keeps a free-running isochronous cycle timer and stretches its short seconds field into a 32-bit running seconds count. The 32-bit timer word has three fields. The low 12 bits are a sub-cycle offset that steps on each 24.576 MHz tick enable. The middle 13 bits are a cycle count. The top 7 bits are seconds. The offset rolls over after 3072 ticks, the cycle count after 8000 cycles, and the seconds field wraps modulo 128.

A 32-bit bus-time store extends the seconds field. Bits 31..7 of the store hold the extended seconds. Bit 6 is a shadow of the last seen top bit of the live seconds field. Bits 5..0 are always zero. A change in that top bit is detected when it happens, and also on any read that comes before that update. Either way it is folded into the upper bits, so a reader never sees the extended count step backwards. The same change sets a sticky event flag, which stays set until the clear input is pulsed. Both words are reached through a simple quadlet register port. Every request gets a response one cycle later.

The register port is a small state machine with three states. PS_IDLE means no response is pending. PS_ACK presents a good response. PS_AERR presents an address-error response. Each state has the same three transitions. A request to a known address moves to PS_ACK. A request to any other address moves to PS_AERR. A cycle with no request returns to PS_IDLE. Requests may follow back to back, so PS_ACK and PS_AERR can move directly to each other.

Top module: `iso_cycle_clock`

## Requirements
- R1: After reset, the timer word and the bus time both read 0x00000000, the event flag is low, and rsp_valid is low.
- R2: On a tick, the offset field (bits 11..0) increments. When the offset is 3071, a tick sets it to 0 and increments the cycle count (bits 24..12). Without a tick, write or init, the timer word holds its value.
- R3: When the count is 7999 and the offset is 3071, a tick clears both fields and increments seconds (bits 31..25) modulo 128.
- R4: The event flag sets one cycle after any change in timer bit 31 caused by a tick or a timer write. It stays set until evt_clr is high in a cycle without a new event. A new event wins over a clear in the same cycle.
- R5: On an event, if the stored shadow bit 6 differs from live timer bit 31, 0x40 is added to the stored bus time.
- R6: A bus-time read (address 0x04) returns the stored value OR the live 7-bit seconds field in bits 6..0. If the shadow differs from the live bit, the read first applies the same +0x40 fold, and the fold is also stored. A second fold never occurs for the same change.
- R7: A bus-time write replaces stored bits 31..7 with the written bits 31..7 and leaves stored bits 6..0 unchanged.
- R8: When a bus-time write falls in the same cycle as an event fold, the written upper bits win and the shadow bit still takes the live value.
- R9: An init_valid pulse loads the timer with init_seconds[6:0] in bits 31..25, with zero count and zero offset. It loads the bus time with init_seconds having bits 5..0 cleared. It raises no event.
- R10: The timer word is at address 0x00 and the bus time at 0x04. Any other address gives rsp_err=1 and data 0, and changes no state. Each request yields exactly one rsp_valid cycle on the next clock. Write responses carry data 0.
- R11: A write to address 0x00 loads all 32 timer bits. A read of address 0x00 returns the current timer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 24.576 MHz tick enable |
| init_valid | input | 1 | Load both words from init_seconds |
| init_seconds | input | 32 | Initial seconds value |
| reg_valid | input | 1 | Register request present |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Address error |
| rsp_data | output | 32 | Read data |
| evt_clr | input | 1 | Clear the event flag |
| evt_flag | output | 1 | Sticky seconds-bit-6 change flag |

## Verification
Two functions can fall in the same cycle: the event-driven fold of the bus time, and a bus-time access on the register port. The bench provokes this by writing the timer so that its top seconds bit flips, then issuing a bus-time write or read in the very next cycle, which is the cycle in which the event pulse is live. For the write case, the following read must show the written upper bits with the shadow matching the live bit. For the read case, the result must show exactly one +0x40 carry, and a repeated read must return the same value. A clear pulse held in the event cycle must leave the flag set.

// File: rtl/iso_cycle_clock_pkg.sv
package iso_cycle_clock_pkg;

    localparam int SEC_W = 7;
    localparam int CNT_W = 13;
    localparam int OFF_W = 12;
    localparam int WORD_W = SEC_W + CNT_W + OFF_W;
    localparam int SHADOW_BIT = SEC_W - 1;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [CNT_W-1:0] cnt;
        logic [OFF_W-1:0] off;
    } cyc_time_t;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_ACK  = 2'd1,
        PS_AERR = 2'd2
    } port_state_t;

endpackage

// File: rtl/iso_cycle_clock_timer.sv
module iso_cycle_clock_timer
    import iso_cycle_clock_pkg::*;
#(
    parameter int OFFSET_MOD = 3072,
    parameter int COUNT_MOD  = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             init_en,
    input  logic [SEC_W-1:0] init_sec,
    input  logic             load_en,
    input  logic [WORD_W-1:0] load_val,
    output cyc_time_t        ct_q,
    output logic             msb_evt
);

    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFFSET_MOD - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COUNT_MOD - 1);

    cyc_time_t ct_d;

    always_comb begin
        ct_d = ct_q;
        if (init_en) begin
            ct_d.sec = init_sec;
            ct_d.cnt = '0;
            ct_d.off = '0;
        end else if (load_en) begin
            ct_d = cyc_time_t'(load_val);
        end else if (tick_en) begin
            if (ct_q.off == OFF_LAST) begin
                ct_d.off = '0;
                if (ct_q.cnt == CNT_LAST) begin
                    ct_d.cnt = '0;
                    ct_d.sec = ct_q.sec + SEC_W'(1);
                end else begin
                    ct_d.cnt = ct_q.cnt + CNT_W'(1);
                end
            end else begin
                ct_d.off = ct_q.off + OFF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q    <= '0;
            msb_evt <= 1'b0;
        end else begin
            ct_q    <= ct_d;
            msb_evt <= !init_en && (ct_d.sec[SHADOW_BIT] != ct_q.sec[SHADOW_BIT]);
        end
    end

endmodule

// File: rtl/iso_cycle_clock_bustime.sv
module iso_cycle_clock_bustime
    import iso_cycle_clock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_en,
    input  logic [WORD_W-1:0] init_val,
    input  logic              fold_en,
    input  logic [SEC_W-1:0]  live_sec,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_val,
    output logic [WORD_W-1:0] bt_q
);

    localparam logic [WORD_W-1:0] FOLD_STEP = WORD_W'(1) << SHADOW_BIT;

    logic [WORD_W-1:0] folded;
    logic [WORD_W-1:0] bt_d;

    always_comb begin
        folded = bt_q;
        if (bt_q[SHADOW_BIT] != live_sec[SHADOW_BIT]) begin
            folded = bt_q + FOLD_STEP;
        end
        rd_val = folded | {{(WORD_W-SEC_W){1'b0}}, live_sec};
    end

    always_comb begin
        bt_d = bt_q;
        if (init_en) begin
            bt_d = {init_val[WORD_W-1:SHADOW_BIT], {SHADOW_BIT{1'b0}}};
        end else begin
            if (fold_en) begin
                bt_d = folded;
            end
            if (wr_en) begin
                bt_d = {wdata[WORD_W-1:SEC_W], bt_d[SEC_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q <= '0;
        end else begin
            bt_q <= bt_d;
        end
    end

endmodule

// File: rtl/iso_cycle_clock_port.sv
module iso_cycle_clock_port
    import iso_cycle_clock_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] ADDR_CYCLE   = 'h00,
    parameter logic [ADDR_W-1:0] ADDR_BUSTIME = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] ct_rd,
    input  logic [WORD_W-1:0] bt_rd,
    output logic              ct_wr_en,
    output logic              bt_wr_en,
    output logic              bt_rd_en,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_data
);

    port_state_t state_q, state_d;
    logic        hit_ct, hit_bt;
    logic [WORD_W-1:0] data_d;

    always_comb begin
        hit_ct   = reg_valid && (reg_addr == ADDR_CYCLE);
        hit_bt   = reg_valid && (reg_addr == ADDR_BUSTIME);
        ct_wr_en = hit_ct && reg_write;
        bt_wr_en = hit_bt && reg_write;
        bt_rd_en = hit_bt && !reg_write;
    end

    always_comb begin
        state_d = PS_IDLE;
        unique case (state_q)
            PS_IDLE, PS_ACK, PS_AERR: begin
                if (!reg_valid)            state_d = PS_IDLE;
                else if (hit_ct || hit_bt) state_d = PS_ACK;
                else                       state_d = PS_AERR;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        data_d = '0;
        if (reg_valid && !reg_write) begin
            if (hit_ct)      data_d = ct_rd;
            else if (hit_bt) data_d = bt_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            rsp_data <= '0;
        end else begin
            state_q  <= state_d;
            rsp_data <= data_d;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            PS_IDLE: ;
            PS_ACK:  rsp_valid = 1'b1;
            PS_AERR: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/iso_cycle_clock.sv
module iso_cycle_clock
    import iso_cycle_clock_pkg::*;
#(
    parameter int                OFFSET_MOD   = 3072,
    parameter int                COUNT_MOD    = 8000,
    parameter int                ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] ADDR_CYCLE   = 'h00,
    parameter logic [ADDR_W-1:0] ADDR_BUSTIME = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              init_valid,
    input  logic [31:0]       init_seconds,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_data,
    input  logic              evt_clr,
    output logic              evt_flag
);

    cyc_time_t         ct_now;
    logic              sec_evt;
    logic [WORD_W-1:0] bt_state;
    logic [WORD_W-1:0] bt_view;
    logic              ct_wr_en, bt_wr_en, bt_rd_en;

    iso_cycle_clock_timer #(
        .OFFSET_MOD (OFFSET_MOD),
        .COUNT_MOD  (COUNT_MOD)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .init_en  (init_valid),
        .init_sec (init_seconds[SEC_W-1:0]),
        .load_en  (ct_wr_en),
        .load_val (reg_wdata),
        .ct_q     (ct_now),
        .msb_evt  (sec_evt)
    );

    iso_cycle_clock_bustime u_bustime (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_en  (init_valid),
        .init_val (init_seconds),
        .fold_en  (sec_evt || bt_rd_en),
        .live_sec (ct_now.sec),
        .wr_en    (bt_wr_en),
        .wdata    (reg_wdata),
        .rd_val   (bt_view),
        .bt_q     (bt_state)
    );

    iso_cycle_clock_port #(
        .ADDR_W       (ADDR_W),
        .ADDR_CYCLE   (ADDR_CYCLE),
        .ADDR_BUSTIME (ADDR_BUSTIME)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .ct_rd     (ct_now),
        .bt_rd     (bt_view),
        .ct_wr_en  (ct_wr_en),
        .bt_wr_en  (bt_wr_en),
        .bt_rd_en  (bt_rd_en),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_data  (rsp_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_flag <= 1'b0;
        end else if (sec_evt) begin
            evt_flag <= 1'b1;
        end else if (evt_clr) begin
            evt_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/iso_cycle_clock_checker.sv
module iso_cycle_clock_checker #(
    parameter int                ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] ADDR_CYCLE   = 'h00,
    parameter logic [ADDR_W-1:0] ADDR_BUSTIME = 'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              init_valid,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              evt_clr,
    input logic              evt_flag,
    input logic [31:0]       ct_now,
    input logic [31:0]       bt_state,
    input logic              sec_evt
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(tick_en) && !$past(init_valid)
        && !$past(reg_valid && reg_write && reg_addr == ADDR_CYCLE)
        |-> ct_now == $past(ct_now)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(evt_flag) && !$past(evt_clr) |-> evt_flag); // R4

    AST_SHADOW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(sec_evt) && !$past(init_valid)
        |-> bt_state[6] == $past(ct_now[31])); // R5

    AST_WRITE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_valid && reg_write && reg_addr == ADDR_BUSTIME && !init_valid)
        |-> bt_state[31:7] == $past(reg_wdata[31:7])); // R7

    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(init_valid) |-> !sec_evt); // R9

    AST_RSP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rsp_valid |-> $past(reg_valid)); // R10

    AST_ERR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rsp_valid && rsp_err
        |-> ($past(reg_addr) != ADDR_CYCLE) && ($past(reg_addr) != ADDR_BUSTIME)); // R10

endmodule

bind iso_cycle_clock iso_cycle_clock_checker #(
    .ADDR_W       (ADDR_W),
    .ADDR_CYCLE   (ADDR_CYCLE),
    .ADDR_BUSTIME (ADDR_BUSTIME)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .init_valid (init_valid),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .evt_clr    (evt_clr),
    .evt_flag   (evt_flag),
    .ct_now     (ct_now),
    .bt_state   (bt_state),
    .sec_evt    (sec_evt)
);

// File: tb/iso_cycle_clock_bench.sv
module iso_cycle_clock_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        init_valid = 1'b0;
    logic [31:0] init_seconds = '0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_data;
    logic        evt_clr = 1'b0;
    logic        evt_flag;

    int n_checks = 0;
    int n_fail = 0;
    logic done = 1'b0;

    iso_cycle_clock u_iso_cycle_clock (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .init_valid   (init_valid),
        .init_seconds (init_seconds),
        .reg_valid    (reg_valid),
        .reg_write    (reg_write),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_err      (rsp_err),
        .rsp_data     (rsp_data),
        .evt_clr      (evt_clr),
        .evt_flag     (evt_flag)
    );

    always #10 clk = ~clk;

    // {write, addr, wdata, expect_err, expect_data}
    localparam int NVEC = 12;
    localparam logic [73:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'h00, 32'h0,        1'b0, 32'h8E000000},  // R11 R9
        {1'b0, 8'h04, 32'h0,        1'b0, 32'h00000A47},  // R9 R6
        {1'b0, 8'h08, 32'h0,        1'b1, 32'h00000000},  // R10
        {1'b1, 8'h04, 32'h12345678, 1'b0, 32'h00000000},  // R7
        {1'b0, 8'h04, 32'h0,        1'b0, 32'h12345647},  // R7
        {1'b1, 8'h0C, 32'hFFFFFFFF, 1'b1, 32'h00000000},  // R10
        {1'b0, 8'h04, 32'h0,        1'b0, 32'h12345647},  // R10
        {1'b0, 8'h00, 32'h0,        1'b0, 32'h8E000000},  // R10
        {1'b1, 8'h04, 32'h0000007F, 1'b0, 32'h00000000},  // R7
        {1'b0, 8'h04, 32'h0,        1'b0, 32'h00000047},  // R7
        {1'b1, 8'h04, 32'h12345678, 1'b0, 32'h00000000},  // R7
        {1'b0, 8'h04, 32'h0,        1'b0, 32'h12345647}   // R7
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [7:0] a, input logic [31:0] d);
        reg_valid = 1'b1;
        reg_write = wr;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0;
        reg_write = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic err, input logic [31:0] data);
        check({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
        check({tag, " err"}, {31'b0, rsp_err}, {31'b0, err});
        check({tag, " data"}, rsp_data, data);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        drive(1'b0, a, 32'h0);
        expect_rsp(tag, 1'b0, exp);
    endtask

    task automatic tick_once();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic clear_flag();
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 evt_flag", {31'b0, evt_flag}, 32'd0);
        check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        rd("R1 timer", 8'h00, 32'h0);
        rd("R1 bustime", 8'h04, 32'h0);

        // R2 offset steps and wraps into count
        tick_once(); tick_once(); tick_once();
        rd("R2 three ticks", 8'h00, 32'h00000003);
        drive(1'b1, 8'h00, 32'h00000BFF);
        expect_rsp("R10 write rsp", 1'b0, 32'h0);
        tick_once();
        rd("R2 offset wrap", 8'h00, 32'h00001000);

        // R3 count wrap into seconds
        drive(1'b1, 8'h00, 32'h01F3FBFF);
        tick_once();
        rd("R3 count wrap", 8'h00, 32'h02000000);

        // R4 R5 seconds bit 6 rises
        drive(1'b1, 8'h00, 32'h7FF3FBFF);
        @(negedge clk);
        check("R4 no event below bit6", {31'b0, evt_flag}, 32'd0);
        tick_once();
        @(negedge clk);
        check("R4 event on rise", {31'b0, evt_flag}, 32'd1);
        rd("R5 fold on rise", 8'h04, 32'h00000040);
        rd("R3 seconds 64", 8'h00, 32'h80000000);
        @(negedge clk);
        check("R4 sticky", {31'b0, evt_flag}, 32'd1);
        clear_flag();
        check("R4 cleared", {31'b0, evt_flag}, 32'd0);

        // R3 R5 seconds wrap modulo 128
        drive(1'b1, 8'h00, 32'hFFF3FBFF);
        tick_once();
        @(negedge clk);
        check("R4 event on fall", {31'b0, evt_flag}, 32'd1);
        rd("R3 seconds wrap", 8'h00, 32'h00000000);
        rd("R5 fold on fall", 8'h04, 32'h00000080);
        clear_flag();

        // R9 init, no event
        init_seconds = 32'h00000A47;
        init_valid = 1'b1;
        @(negedge clk);
        init_valid = 1'b0;
        @(negedge clk);
        check("R9 no event on init", {31'b0, evt_flag}, 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][73], VEC[i][72:65], VEC[i][64:33]);
            expect_rsp($sformatf("R10 vec%0d", i), VEC[i][32], VEC[i][31:0]);
        end

        // R8 bus-time write coinciding with event fold (stored 0x12345640, sec 0x47)
        drive(1'b1, 8'h00, 32'h00000000);
        drive(1'b1, 8'h04, 32'hABCDEF00);
        rd("R8 write wins shadow refreshed", 8'h04, 32'hABCDEF00);
        check("R8 event seen", {31'b0, evt_flag}, 32'd1);
        clear_flag();

        // R6 read coinciding with event fold, single fold
        drive(1'b1, 8'h00, 32'h8E000000);
        rd("R6 read in event cycle", 8'h04, 32'hABCDEF47);
        rd("R6 no double fold", 8'h04, 32'hABCDEF47);
        clear_flag();

        // R6 read carry from bit 6 into bit 7
        drive(1'b1, 8'h00, 32'h00000000);
        rd("R6 read carry", 8'h04, 32'hABCDEF80);
        rd("R6 carry stored", 8'h04, 32'hABCDEF80);
        clear_flag();

        // R4 event wins over clear in the same cycle
        drive(1'b1, 8'h00, 32'h80000000);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        check("R4 set beats clear", {31'b0, evt_flag}, 32'd1);
        clear_flag();

        // R9 init while live bit 6 is set, still no event
        init_seconds = 32'h00000000;
        init_valid = 1'b1;
        @(negedge clk);
        init_valid = 1'b0;
        @(negedge clk);
        check("R9 init quiet", {31'b0, evt_flag}, 32'd0);
        rd("R9 timer cleared", 8'h00, 32'h00000000);
        rd("R9 bustime cleared", 8'h04, 32'h00000000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule